// File: doc/BRIEF.md
# Loadable Pace Interval Timer

This block enforces a minimum spacing between successive conversions of a sampling sequencer. The host writes an interval value into a staging register. Each time the sequencer starts a conversion cycle, it pulses a reload strobe. The timer then loads the staged value and counts upward by one per clock. Until the count reaches all-ones, the block holds the sequencer back. When the count reaches all-ones, the carry out of the counter's top stage releases the sequencer, and the counter parks at all-ones until the next reload.

A larger stored value gives a shorter interval. A stored value of V keeps the sequencer held for (2^16 - 1) - V clocks after the reload edge. When external pacing is selected, the hold output is forced inactive, so the timer never blocks a conversion, although it keeps counting in the background. A host write changes only the staged value. The running count picks it up at the next reload and never in the middle of an interval.

Top module: `pace_interval_timer`

## Requirements
- R1: After synchronous reset, timer_val is 16'hFFFF, seq_hold is 0, and the staged interval is 16'hFFFF, so a reload with no prior write leaves seq_hold at 0.
- R2: A write with pace_wr stores pace_wdata in the staging register. A later reload makes timer_val equal that value on the clock after the reload edge.
- R3: While timer_val is below 16'hFFFF and no reload occurs, timer_val rises by exactly one on every clock.
- R4: After a reload of value V, seq_hold stays at 1 for exactly 16'hFFFF - V clocks and then falls. timer_val then stays at 16'hFFFF until the next reload.
- R5: A write that occurs during an interval changes neither timer_val nor seq_hold. The new value is used only at the following reload.
- R6: When pace_wr and reload are high in the same cycle, the counter loads the value staged before that write, and the written value applies from the next reload.
- R7: A reload that arrives while an interval is still running restarts the count from the staged value.
- R8: While int_pace_off is 1, seq_hold is 0 and the counter keeps advancing. When int_pace_off returns to 0 before the count ends, seq_hold returns to 1.
- R9: Reloading the value 16'hFFFF gives an interval of zero clocks, so seq_hold stays at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pace_wr | input | 1 | Host write strobe for the staged interval |
| pace_wdata | input | 16 | Interval value written by the host |
| reload | input | 1 | Conversion-cycle event that restarts the interval |
| int_pace_off | input | 1 | 1 = internal pacing disabled, external pacing in control |
| timer_val | output | 16 | Current count |
| seq_hold | output | 1 | 1 = sequencer held; falls at terminal count |

## Verification
A corrupted count shows directly on timer_val one clock after it happens. It also moves the falling edge of seq_hold, so the length of an interval becomes longer or shorter than (2^16 - 1) - V. A broken carry between counter stages appears the first time a nibble wraps, which takes at most 16 clocks into an interval. A staging register that leaks into the running count shows up on the cycle after a mid-interval write, and the wrong value at the reload on the write cycle shows up on the clock after that reload.

// File: rtl/pace_timer_pkg.sv
package pace_timer_pkg;
    localparam int PACE_W  = 16;
    localparam int STAGE_W = 4;

    typedef logic [PACE_W-1:0] pace_t;

    typedef struct packed {
        logic  wr;
        pace_t data;
    } pace_write_t;

    function automatic logic is_terminal(input pace_t v);
        return &v;
    endfunction
endpackage

// File: rtl/pace_stage_reg.sv
module pace_stage_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] stored
);
    always_ff @(posedge clk) begin
        if (rst)
            stored <= '1;
        else if (wr)
            stored <= wdata;
    end
endmodule

// File: rtl/pace_count_stage.sv
module pace_count_stage #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         advance,
    input  logic         ones_in,
    output logic [W-1:0] cnt_q,
    output logic         ones_out
);
    // ones_in: every lower stage is all-ones, so this stage takes the carry
    assign ones_out = ones_in & (&cnt_q);

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '1;
        else if (load)
            cnt_q <= load_val;
        else if (advance && ones_in)
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/pace_interval_timer.sv
module pace_interval_timer
    import pace_timer_pkg::*;
#(
    parameter int PACE_WIDTH = PACE_W,
    parameter int STAGE_WIDTH = STAGE_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  pace_wr,
    input  logic [PACE_WIDTH-1:0] pace_wdata,
    input  logic                  reload,
    input  logic                  int_pace_off,
    output logic [PACE_WIDTH-1:0] timer_val,
    output logic                  seq_hold
);
    localparam int NSTAGE = PACE_WIDTH / STAGE_WIDTH;

    logic [PACE_WIDTH-1:0] pace_q;
    logic [NSTAGE:0]       ones_chain;
    logic                  term_cnt;
    logic                  advance;

    pace_stage_reg #(.W(PACE_WIDTH)) u_stage (
        .clk    (clk),
        .rst    (rst),
        .wr     (pace_wr),
        .wdata  (pace_wdata),
        .stored (pace_q)
    );

    assign ones_chain[0] = 1'b1;

    for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
        pace_count_stage #(.W(STAGE_WIDTH)) u_cnt (
            .clk      (clk),
            .rst      (rst),
            .load     (reload),
            .load_val (pace_q[s*STAGE_WIDTH +: STAGE_WIDTH]),
            .advance  (advance),
            .ones_in  (ones_chain[s]),
            .cnt_q    (timer_val[s*STAGE_WIDTH +: STAGE_WIDTH]),
            .ones_out (ones_chain[s+1])
        );
    end

    // carry out of the most significant stage marks terminal count
    assign term_cnt = ones_chain[NSTAGE];
    assign advance  = ~term_cnt;
    assign seq_hold = ~term_cnt & ~int_pace_off;
endmodule

// File: rtl/pace_interval_timer_chk.sv
module pace_interval_timer_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         pace_wr,
    input logic [W-1:0] pace_wdata,
    input logic         reload,
    input logic         int_pace_off,
    input logic [W-1:0] pace_q,
    input logic [W-1:0] timer_val,
    input logic         seq_hold
);
    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> ((&timer_val) && !seq_hold));

    // R2
    write_store_chk: assert property (@(posedge clk) disable iff (rst)
        pace_wr |=> (pace_q == $past(pace_wdata)));

    // R2
    reload_load_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(reload) && !$past(rst)) |-> (timer_val == $past(pace_q)));

    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(reload) && !(&$past(timer_val)))
            |-> (timer_val == $past(timer_val) + 1'b1));

    // R4
    park_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(reload) && (&$past(timer_val))) |-> (&timer_val));

    // R5
    stage_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(pace_wr)) |-> $stable(pace_q));

    // R8
    ext_pace_chk: assert property (@(posedge clk) disable iff (rst)
        int_pace_off |-> !seq_hold);

    // R8
    int_pace_chk: assert property (@(posedge clk) disable iff (rst)
        (!int_pace_off && !(&timer_val)) |-> seq_hold);
endmodule

bind pace_interval_timer pace_interval_timer_chk #(.W(PACE_WIDTH)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .pace_wr      (pace_wr),
    .pace_wdata   (pace_wdata),
    .reload       (reload),
    .int_pace_off (int_pace_off),
    .pace_q       (pace_q),
    .timer_val    (timer_val),
    .seq_hold     (seq_hold)
);

// File: tb/pace_interval_timer_test.sv
module pace_interval_timer_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pace_wr = 1'b0;
    logic [15:0] pace_wdata = '0;
    logic        reload = 1'b0;
    logic        int_pace_off = 1'b0;
    logic [15:0] timer_val;
    logic        seq_hold;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    logic [15:0] m_cnt;
    logic [15:0] m_pace;

    pace_interval_timer uut (
        .clk          (clk),
        .rst          (rst),
        .pace_wr      (pace_wr),
        .pace_wdata   (pace_wdata),
        .reload       (reload),
        .int_pace_off (int_pace_off),
        .timer_val    (timer_val),
        .seq_hold     (seq_hold)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] next_cnt(input logic [15:0] c, input logic [15:0] p,
                                             input logic rl);
        if (rl) return p;
        if (c != 16'hFFFF) return c + 16'd1;
        return c;
    endfunction

    function automatic logic exp_hold(input logic [15:0] c, input logic off);
        return (c != 16'hFFFF) && !off;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive at negedge, apply one clock, update model, return at next negedge
    task automatic tick(input logic wr, input logic [15:0] d, input logic rl, input logic off);
        pace_wr = wr; pace_wdata = d; reload = rl; int_pace_off = off;
        @(posedge clk);
        if (rst) begin
            m_cnt = 16'hFFFF; m_pace = 16'hFFFF;
        end else begin
            m_cnt = next_cnt(m_cnt, m_pace, rl);
            if (wr) m_pace = d;
        end
        @(negedge clk);
        pace_wr = 1'b0; reload = 1'b0;
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 200000) begin
                errors++;
                $display("FAIL watchdog actual=%0d expected=<200000", cycles);
                $display("  CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        int n;
        void'($urandom(32'd4711));
        m_cnt = 16'hFFFF; m_pace = 16'hFFFF;
        @(negedge clk);
        repeat (3) tick(0, 16'h0, 0, 0);
        rst = 1'b0;
        tick(0, 16'h0, 0, 0);
        // R1: reset state
        chk("R1 timer", timer_val, 16'hFFFF);
        chk("R1 hold", seq_hold, 0);
        tick(0, 16'h0, 1, 0);
        chk("R1 reload default", timer_val, 16'hFFFF);
        chk("R1 hold after reload", seq_hold, 0);

        // R5: write while parked leaves count alone
        tick(1, 16'hFFF0, 0, 0);
        chk("R5 write no effect", timer_val, 16'hFFFF);
        // R2: reload loads staged value
        tick(0, 16'h0, 1, 0);
        chk("R2 load", timer_val, 16'hFFF0);
        chk("R2 hold", seq_hold, 1);
        tick(0, 16'h0, 0, 0);
        tick(0, 16'h0, 0, 0);
        // R3: counts by one
        chk("R3 step", timer_val, 16'hFFF2);
        // R5: write mid-interval does not disturb count
        tick(1, 16'hFF00, 0, 0);
        chk("R5 mid write", timer_val, 16'hFFF3);
        chk("R5 mid write hold", seq_hold, 1);
        tick(1, 16'hFFF0, 0, 0);
        // R4: interval length from reload
        tick(0, 16'h0, 1, 0);
        n = 0;
        while (seq_hold && n < 100) begin
            tick(0, 16'h0, 0, 0);
            n++;
        end
        chk("R4 interval", n, 15);
        repeat (5) tick(0, 16'h0, 0, 0);
        chk("R4 park", timer_val, 16'hFFFF);
        chk("R4 park hold", seq_hold, 0);

        // R6: write and reload together use old value
        tick(1, 16'hFFE0, 1, 0);
        chk("R6 old value", timer_val, 16'hFFF0);
        repeat (3) tick(0, 16'h0, 0, 0);
        // R7: reload mid-interval restarts
        tick(0, 16'h0, 1, 0);
        chk("R7 restart", timer_val, 16'hFFE0);
        chk("R6 new value hold", seq_hold, 1);

        // R8: external pacing masks hold, counter advances
        tick(0, 16'h0, 0, 1);
        chk("R8 hold masked", seq_hold, 0);
        tick(0, 16'h0, 0, 1);
        chk("R8 counting", timer_val, 16'hFFE2);
        tick(0, 16'h0, 0, 0);
        chk("R8 hold back", seq_hold, 1);

        // R9: zero-length interval
        tick(1, 16'hFFFF, 0, 0);
        tick(0, 16'h0, 1, 0);
        chk("R9 no hold", seq_hold, 0);
        chk("R9 timer", timer_val, 16'hFFFF);

        // randomized traffic against model
        for (int i = 0; i < 4000; i++) begin
            logic wr, rl, off;
            logic [15:0] d;
            wr  = ($urandom % 8) == 0;
            rl  = ($urandom % 24) == 0;
            off = ($urandom % 10) == 0;
            d   = 16'hFFFF - 16'($urandom % 48);
            if (($urandom % 200) == 0) d = 16'hFFFF;
            tick(wr, d, rl, off);
            // R3 R4 R8 model compare
            chk("R3 random count", timer_val, m_cnt);
            chk("R4 random hold", seq_hold, exp_hold(m_cnt, off));
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule